// File: doc/BRIEF.md
# Priority-resolved dual-port CAM

This block is a 32-entry content-addressable store. Every entry keeps an 8-bit tag, an 8-bit data value and a valid flag. A single 32-bit instruction word drives the block on each clock, and a 32-bit result word carries the answers. Software-visible priority is fixed by position: when two or more valid entries carry the searched tag, the one with the smallest index answers.

One instruction can carry any one of the following:
- two independent tag searches, which are both answered one cycle later;
- two independent invalidates, which both take effect on the same edge;
- one write to an explicitly addressed entry.

A write fills the whole instruction word, so only one write can be issued per instruction. No replacement policy is applied beyond the address given in the write.

Top module: `pcam_top`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid, so every search misses, and the result word is all zeros.
- R2: Opcode `instr_i[31:30]=10` writes the entry whose index is in `instr_i[20:16]`, setting tag `instr_i[15:8]` and data `instr_i[7:0]` and marking the entry valid. A search issued in the next instruction finds it.
- R3: Opcode `01` searches tag A `instr_i[15:8]` and tag B `instr_i[7:0]` at the same time. One clock later, `result_o` holds:
  - `[27]` hit A, `[26:22]` index A, `[21:14]` data A;
  - `[13]` hit B, `[12:8]` index B, `[7:0]` data B;
  - `[31:28]` zero.
- R4: When several valid entries hold the searched tag, the reported index and data come from the lowest-indexed of them.
- R5: On a miss, the hit flag, index field and data field of that port are all zero.
- R6: Opcode `11` clears the valid flag of every valid entry whose tag equals either `instr_i[15:8]` or `instr_i[7:0]`. Entries with other tags are not affected.
- R7: Opcodes `00` (no-op), `10` and `11` leave `result_o` unchanged.
- R8: Writing an entry that is already valid replaces its tag and data. The old tag no longer matches that entry, and the next-lowest holder of the old tag then wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_i | input | 32 | Instruction word: opcode and fields |
| result_o | output | 32 | Registered dual search result |

## Verification
The bench writes one tag at several addresses and checks that the lowest index answers. It then re-tags that entry and checks that the next-lowest holder wins; an encoder scanning in the wrong direction would return the highest index, and a write that failed to drop the old tag would keep answering with the stale entry.

Dual invalidates are checked to clear every copy of both tags while leaving other entries in place. A design that cleared only the first match, or only port A's tag, would then report hits that should be misses.

Both ports are checked for a zero index and zero data on a miss, which catches a design that leaks the data of entry 0. Non-search opcodes are checked to hold the result word, which catches a result register that reloads on every cycle.

Random traffic uses a narrow tag range so that collisions between entries are frequent.

// File: rtl/pcam_pkg.sv
// Shared opcode type for the priority-resolved CAM.
package pcam_pkg;
    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_INVAL = 2'b11
    } pcam_op_e;
endpackage

// File: rtl/cam_store.sv
// Entry storage and tag comparators.
// Holds N entries of tag, data and a valid flag. It compares two search keys
// against every entry in parallel and reports one match vector per key. Write
// and invalidate arrive on separate enables and are assumed never to be active
// in the same cycle (the opcode decode guarantees this). Invalidate clears
// every entry that matches either key.
module cam_store #(
    parameter int N  = 32,
    parameter int TW = 8,
    parameter int DW = 8,
    parameter int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [TW-1:0]   wr_tag,
    input  logic [DW-1:0]   wr_data,
    input  logic            inv_en,
    input  logic [TW-1:0]   key_a,
    input  logic [TW-1:0]   key_b,
    output logic [N-1:0]    match_a,
    output logic [N-1:0]    match_b,
    output logic [N*DW-1:0] data_flat
);
    logic [N-1:0]  valid;
    logic [TW-1:0] tags [N];
    logic [DW-1:0] vals [N];

    for (genvar g = 0; g < N; g++) begin : g_entry
        // Comparators: a hit needs a valid entry with an equal tag.
        assign match_a[g] = valid[g] && (tags[g] == key_a);
        assign match_b[g] = valid[g] && (tags[g] == key_b);
        assign data_flat[g*DW +: DW] = vals[g];

        // Valid flag: reset clears it, a write sets it, a matching invalidate clears it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                valid[g] <= 1'b0;
            else if (wr_en && wr_idx == IW'(g))
                valid[g] <= 1'b1;
            else if (inv_en && (match_a[g] || match_b[g]))
                valid[g] <= 1'b0;
        end

        // Payload: loaded by a write to this entry only.
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IW'(g)) begin
                tags[g] <= wr_tag;
                vals[g] <= wr_data;
            end
        end
    end

    // A written entry is valid on the next cycle.
    assert_write_sets_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid[$past(wr_idx)])
        else $error("write did not set valid");

    // Nothing that matched an invalidate key survives.
    assert_inval_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |=> ((valid & $past(match_a | match_b)) == '0))
        else $error("invalidate left a matching entry");
endmodule

// File: rtl/prio_pick.sv
// Fixed-priority encoder.
// Reports whether any request bit is set and gives the index of the lowest
// set bit. Bit 0 has the highest priority.
module prio_pick #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    logic [N-1:0] below_mask;

    // Scan from the top down so that the lowest set bit is written last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        hit = |req;
    end

    // Mask of the bits below the chosen index, used only by the check.
    always_comb begin
        below_mask = (N'(1) << idx) - N'(1);
        if (hit) begin
            assert_lowest_wins_R4: assert (req[idx] && ((req & below_mask) == '0))
                else $error("encoder did not pick lowest request");
        end
    end
endmodule

// File: rtl/pcam_top.sv
// Priority-resolved dual-port CAM, top level.
// Decodes the 32-bit instruction into one write, two invalidates or two
// searches. Each search resolves to its lowest-indexed matching entry. The
// results are registered into a 32-bit word that changes only on search
// instructions. Reset is synchronous and active low.
module pcam_top #(
    parameter int N     = 32,
    parameter int TW    = 8,
    parameter int DW    = 8,
    parameter int WORD  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WORD-1:0] instr_i,
    output logic [WORD-1:0] result_o
);
    import pcam_pkg::*;

    localparam int IW     = $clog2(N);
    localparam int PORT_W = 1 + IW + DW;
    localparam int PAD_W  = WORD - 2 * PORT_W;

    pcam_op_e       op;
    logic           wr_en, inv_en, rd_en;
    logic [TW-1:0]  key_a, key_b;
    logic [N-1:0]   match_a, match_b;
    logic [N*DW-1:0] data_flat;
    logic           hit_a, hit_b;
    logic [IW-1:0]  idx_a, idx_b;
    logic [DW-1:0]  dat_a, dat_b;

    // Opcode and field decode; enables are held off while reset is active.
    always_comb begin
        op     = pcam_op_e'(instr_i[WORD-1 -: 2]);
        wr_en  = rst_n && (op == OP_WRITE);
        inv_en = rst_n && (op == OP_INVAL);
        rd_en  = rst_n && (op == OP_READ);
        key_a  = instr_i[2*TW-1:TW];
        key_b  = instr_i[TW-1:0];
    end

    cam_store #(.N(N), .TW(TW), .DW(DW), .IW(IW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (instr_i[DW+TW+IW-1:DW+TW]),
        .wr_tag    (instr_i[DW+TW-1:DW]),
        .wr_data   (instr_i[DW-1:0]),
        .inv_en    (inv_en),
        .key_a     (key_a),
        .key_b     (key_b),
        .match_a   (match_a),
        .match_b   (match_b),
        .data_flat (data_flat)
    );

    prio_pick #(.N(N), .IW(IW)) u_pick_a (.req(match_a), .hit(hit_a), .idx(idx_a));
    prio_pick #(.N(N), .IW(IW)) u_pick_b (.req(match_b), .hit(hit_b), .idx(idx_b));

    // Winner data select, forced to zero on a miss.
    always_comb begin
        dat_a = hit_a ? data_flat[idx_a*DW +: DW] : '0;
        dat_b = hit_b ? data_flat[idx_b*DW +: DW] : '0;
    end

    // Result register: loads only on a search, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result_o <= '0;
        else if (rd_en)
            result_o <= {{PAD_W{1'b0}}, hit_a, idx_a, dat_a, hit_b, idx_b, dat_b};
    end

    // Non-search instructions leave the result word alone.
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !rd_en) |=> $stable(result_o))
        else $error("result changed on a non-search opcode");

    // A search answers one cycle later with the hit state of its port.
    assert_search_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (result_o[2*PORT_W-1] == $past(|match_a)) && (result_o[PORT_W-1] == $past(|match_b)))
        else $error("search hit flag mismatch");

    // A miss reports zero index and zero data on both ports.
    assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((result_o[2*PORT_W-1] || result_o[2*PORT_W-2:PORT_W] == '0) &&
                  (result_o[PORT_W-1] || result_o[PORT_W-2:0] == '0)))
        else $error("miss carries nonzero fields");
endmodule

// File: tb/pcam_top_test.sv
`timescale 1ns/1ps
module pcam_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] result;
    int checks = 0;
    int failures = 0;

    logic       mv [32];
    logic [7:0] mt [32];
    logic [7:0] md [32];
    logic [31:0] exp_res = '0;

    pcam_top uut (.clk(clk), .rst_n(rst_n), .instr_i(instr), .result_o(result));

    always #5 clk = ~clk;

    function automatic logic [13:0] look(input logic [7:0] t);
        for (int i = 0; i < 32; i++)
            if (mv[i] && mt[i] == t) return {1'b1, 5'(i), md[i]};
        return 14'h0;
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] want, input string req);
        checks++;
        if (got !== want) begin
            failures++;
            $display("FAIL %s: result=%h expected=%h", req, got, want);
        end
    endtask

    // Apply one instruction, update the model and check the result word.
    task automatic run(input logic [31:0] w, input string req);
        instr = w;
        @(posedge clk);
        #1;
        case (w[31:30])
            2'b01: exp_res = {4'b0, look(w[15:8]), look(w[7:0])};
            2'b10: begin mv[w[20:16]] = 1'b1; mt[w[20:16]] = w[15:8]; md[w[20:16]] = w[7:0]; end
            2'b11: for (int i = 0; i < 32; i++)
                       if (mv[i] && (mt[i] == w[15:8] || mt[i] == w[7:0])) mv[i] = 1'b0;
            default: ;
        endcase
        check(result, exp_res, req);
    endtask

    function automatic logic [31:0] wr(input int a, input logic [7:0] t, input logic [7:0] d);
        return {2'b10, 9'b0, 5'(a), t, d};
    endfunction
    function automatic logic [31:0] rd(input logic [7:0] ta, input logic [7:0] tb);
        return {2'b01, 14'b0, ta, tb};
    endfunction
    function automatic logic [31:0] iv(input logic [7:0] ta, input logic [7:0] tb);
        return {2'b11, 14'b0, ta, tb};
    endfunction

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog: result=%h expected=finish", result);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 32; i++) begin mv[i] = 1'b0; mt[i] = '0; md[i] = '0; end
        repeat (3) @(posedge clk);
        #1;
        check(result, 32'h0, "R1 reset result");
        rst_n = 1'b1;
        run(rd(8'h00, 8'hFF), "R1 empty after reset");
        run(rd(8'h5A, 8'h13), "R1 R5 miss both");

        // R2/R4: one tag at three addresses, the lowest answers on both ports.
        run(wr(20, 8'h5A, 8'hC3), "R2 write");
        run(wr(7,  8'h5A, 8'h77), "R2 write");
        run(wr(3,  8'h5A, 8'h31), "R2 write");
        run(rd(8'h5A, 8'h5A), "R4 lowest index both ports");
        check(result, {4'b0, 1'b1, 5'd3, 8'h31, 1'b1, 5'd3, 8'h31}, "R3 field layout");
        run(32'h0, "R7 nop holds");
        run(wr(9, 8'h44, 8'h99), "R7 write holds");
        run(rd(8'h44, 8'h01), "R5 port B miss");
        // R8: re-tag the winner, the next-lowest holder takes over.
        run(wr(3, 8'hE0, 8'h0E), "R8 overwrite");
        run(rd(8'h5A, 8'hE0), "R8 next lowest wins");
        run(iv(8'h5A, 8'h00), "R7 invalidate holds");
        run(rd(8'h5A, 8'h44), "R6 all copies cleared, others kept");
        run(iv(8'h77, 8'h44), "R6 port B tag cleared");
        run(rd(8'hE0, 8'h44), "R6 after second invalidate");
        run(wr(31, 8'hE0, 8'hAB), "R2 write last entry");
        run(iv(8'hE0, 8'hE0), "R6 same tag on both keys");
        run(rd(8'hE0, 8'hE0), "R6 R5 both cleared");

        // Random traffic with a narrow tag range so collisions are common.
        for (int n = 0; n < 3000; n++) begin
            int unsigned r = $urandom % 10;
            logic [7:0] ta = 8'($urandom % 6);
            logic [7:0] tb = 8'($urandom % 6);
            if (r < 4)      run(wr($urandom % 32, ta, 8'($urandom)), "R2 random write");
            else if (r < 8) run(rd(ta, tb), "R3/R4 random search");
            else if (r < 9) run(iv(ta, tb), "R6 random invalidate");
            else            run(32'h0, "R7 random nop");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule